// File: doc/BRIEF.md
# Supply Undervoltage Monitor Controller

This block is the digital side of a supply-voltage monitor. Two comparator results come from the analog side: one says the supply is below the falling trip level and the other says it is above the higher rising trip level. After the block brings both into the clock domain, it derives a software-visible level status bit. On every change of that bit it sets an event flag, and it raises an interrupt when that flag is enabled. While the monitor is active and resets are allowed, the block holds a system reset request from a falling-level crossing until the supply climbs back above the rising level. That hysteresis keeps the reset from chattering.

Configuration comes in on pins: monitor power-down, reset disable, and permission to keep running in stop mode. A small register port holds the interrupt enable, a write-one acknowledge, the read-only flag and status, and the 2-bit trip-level select that goes to the analog side. The trip select returns to the low-voltage setting on every power-on reset. A monitor reset leaves it untouched.

Top module: `lvmon_ctrl`

## Requirements
- R1: While por_n is low and right after its release: sys_rst_o=0, rst_pin_n_o=1, irq_o=0, trip_sel_o=2'b00 (low-voltage setting), and the control register (address 0) reads 0.
- R2: Control register bit 3 (status) reads the synchronised below-falling comparator when the monitor is active, and 0 otherwise. It follows an input change within 4 clock edges.
- R3: With cfg_pwr_dis=1 the monitor is inactive: status reads 0 and no reset request is raised, even with the supply below the falling level.
- R4: With the monitor active and cfg_rst_dis=0, a below-falling comparator result raises sys_rst_o.
- R5: Once raised, sys_rst_o stays high while the rising comparator reads 0, including between the two levels. It drops only after the rising comparator reads 1.
- R6: rst_pin_n_o is always the inverse of sys_rst_o.
- R7: Every change of the status bit, 0-to-1 or 1-to-0, sets the event flag (control bit 2).
- R8: irq_o is 1 exactly while the event flag and the interrupt enable (control bit 0) are both 1.
- R9: Writing 1 to control bit 1 clears the event flag. Writing 0 there leaves the flag alone. Bit 1 always reads 0.
- R10: A status change in the same cycle as an acknowledge write leaves the flag set.
- R11: Raising a monitor reset clears the interrupt enable. Writes that set it are ignored while the reset is held.
- R12: The trip select (address 1, bits [1:0], driven on trip_sel_o) is software-writable. It keeps its value through a monitor reset and returns to 2'b00 on every power-on reset.
- R13: While stop_i=1 the monitor is inactive unless cfg_stop_en=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| cmp_below_fall_i | input | 1 | Analog: supply below falling trip level |
| cmp_above_rise_i | input | 1 | Analog: supply above rising trip level |
| cfg_pwr_dis | input | 1 | Configuration: monitor powered down |
| cfg_rst_dis | input | 1 | Configuration: reset request disabled |
| cfg_stop_en | input | 1 | Configuration: keep monitoring in stop mode |
| stop_i | input | 1 | Chip is in stop mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| trip_sel_o | output | TRIP_W | Trip level select to analog side |
| irq_o | output | 1 | Interrupt request |
| sys_rst_o | output | 1 | System reset request |
| rst_pin_n_o | output | 1 | External reset pin drive, active low |

## Verification
The status path is driven with a rising and then a falling comparator step. Checking the flag after each step separates a both-edges detector from a single-edge one. The reset path is stepped below the falling level, then into the band between levels, then above the rising level. This shows true hysteresis as opposed to a reset that follows one comparator. Tests with power-down and with stop mode, each with stop permission off and then on, show that gating acts on both status and reset. An acknowledge placed in the exact cycle of a status change shows whether a new event can be lost.

// File: rtl/lvmon_pkg.sv
package lvmon_pkg;
  // Register addresses
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned TRIP_ADDR = 1;
  // Control register bit positions
  localparam int unsigned IE_BIT    = 0;
  localparam int unsigned ACK_BIT   = 1;
  localparam int unsigned FLAG_BIT  = 2;
  localparam int unsigned STAT_BIT  = 3;

  typedef enum logic {
    HOLD_IDLE = 1'b0,
    HOLD_RST  = 1'b1
  } hold_state_e;
endpackage

// File: rtl/lvmon_rstsync.sv
module lvmon_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/lvmon_sync.sv
module lvmon_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;

    always_comb begin
      stg_d = {stg_q[STAGES-2:0], async_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= stg_d;
    end

    assign sync_o[b] = stg_q[STAGES-1];
  end
endmodule

// File: rtl/lvmon_hold.sv
module lvmon_hold
  import lvmon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,     // monitor active and reset allowed
  input  logic below_i,   // synchronised below-falling result
  input  logic above_i,   // synchronised above-rising result
  output logic hold_o,
  output logic hold_next_o
);
  hold_state_e state_q;
  hold_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HOLD_IDLE: if (arm_i && below_i)   state_d = HOLD_RST;
      HOLD_RST:  if (!arm_i || above_i)  state_d = HOLD_IDLE;
      default:                           state_d = HOLD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HOLD_IDLE;
    else        state_q <= state_d;
  end

  assign hold_o      = (state_q == HOLD_RST);
  assign hold_next_o = (state_d == HOLD_RST);
endmodule

// File: rtl/lvmon_irq.sv
module lvmon_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic status_i,
  input  logic ack_i,
  input  logic ie_wr_i,
  input  logic ie_wdata_i,
  input  logic ie_kill_i,
  output logic flag_o,
  output logic ie_o,
  output logic irq_o
);
  logic status_prev_q;
  logic flag_q, flag_d;
  logic ie_q, ie_d;
  logic toggle;

  assign toggle = status_i ^ status_prev_q;

  always_comb begin
    // a fresh event outranks a simultaneous acknowledge
    flag_d = toggle | (flag_q & ~ack_i);
    ie_d   = ie_q;
    if (ie_wr_i) ie_d = ie_wdata_i;
    if (ie_kill_i) ie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_prev_q <= 1'b0;
      flag_q        <= 1'b0;
      ie_q          <= 1'b0;
    end else begin
      status_prev_q <= status_i;
      flag_q        <= flag_d;
      ie_q          <= ie_d;
    end
  end

  assign flag_o = flag_q;
  assign ie_o   = ie_q;
  assign irq_o  = flag_q & ie_q;
endmodule

// File: rtl/lvmon_ctrl.sv
module lvmon_ctrl
  import lvmon_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 1,
  parameter int unsigned TRIP_W      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [TRIP_W-1:0] TRIP_RST = '0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              cmp_below_fall_i,
  input  logic              cmp_above_rise_i,
  input  logic              cfg_pwr_dis,
  input  logic              cfg_rst_dis,
  input  logic              cfg_stop_en,
  input  logic              stop_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [TRIP_W-1:0] trip_sel_o,
  output logic              irq_o,
  output logic              sys_rst_o,
  output logic              rst_pin_n_o
);
  localparam int unsigned CMP_W = 2;

  logic             rst_n_i;
  logic [CMP_W-1:0] cmp_s;
  logic             below_s, above_s;
  logic             active, status;
  logic             wr_ctrl, wr_trip, ack_wr;
  logic             hold, hold_next;
  logic             flag, irq_en;
  logic [TRIP_W-1:0] trip_q, trip_d;
  logic             unused_wdata;

  lvmon_rstsync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (rst_n_i)
  );

  lvmon_sync #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .async_i ({cmp_above_rise_i, cmp_below_fall_i}),
    .sync_o  (cmp_s)
  );
  assign below_s = cmp_s[0];
  assign above_s = cmp_s[1];

  // monitor gating: power-down, or stop mode without permission
  assign active = ~cfg_pwr_dis & ~(stop_i & ~cfg_stop_en);
  assign status = active & below_s;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign wr_trip = wr_en && (wr_addr == ADDR_W'(TRIP_ADDR));
  assign ack_wr  = wr_ctrl && wr_data[ACK_BIT];

  lvmon_hold u_hold (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .arm_i       (active & ~cfg_rst_dis),
    .below_i     (below_s),
    .above_i     (above_s),
    .hold_o      (hold),
    .hold_next_o (hold_next)
  );

  lvmon_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .status_i   (status),
    .ack_i      (ack_wr),
    .ie_wr_i    (wr_ctrl),
    .ie_wdata_i (wr_data[IE_BIT]),
    .ie_kill_i  (hold_next),
    .flag_o     (flag),
    .ie_o       (irq_en),
    .irq_o      (irq_o)
  );

  // trip select: cleared only by power-on reset
  always_comb begin
    trip_d = trip_q;
    if (wr_trip) trip_d = wr_data[TRIP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) trip_q <= TRIP_RST;
    else          trip_q <= trip_d;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(CTRL_ADDR)) begin
      rd_data[IE_BIT]   = irq_en;
      rd_data[FLAG_BIT] = flag;
      rd_data[STAT_BIT] = status;
    end else if (rd_addr == ADDR_W'(TRIP_ADDR)) begin
      rd_data[TRIP_W-1:0] = trip_q;
    end
  end

  assign unused_wdata = ^wr_data;

  assign trip_sel_o  = trip_q;
  assign sys_rst_o   = hold;
  assign rst_pin_n_o = ~hold;
endmodule

// File: rtl/lvmon_chk.sv
module lvmon_chk
  import lvmon_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 1
) (
  input logic              clk,
  input logic              rst_n_i,
  input logic              sys_rst_o,
  input logic              rst_pin_n_o,
  input logic              irq_en,
  input logic              flag,
  input logic              status,
  input logic              above_s,
  input logic              active,
  input logic              cfg_rst_dis,
  input logic              ack_wr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data
);
  // R6
  pin_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    rst_pin_n_o != sys_rst_o);

  // R11
  ie_cleared_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    sys_rst_o |-> !irq_en);

  // R5
  hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (sys_rst_o && !above_s && active && !cfg_rst_dis) |=> sys_rst_o);

  // R5
  release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(sys_rst_o) |-> $past(above_s || !active || cfg_rst_dis));

  // R7
  toggle_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (status != $past(status)) |=> flag);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (flag && !ack_wr) |=> flag);

  // R9
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_addr == ADDR_W'(CTRL_ADDR)) |-> !rd_data[ACK_BIT]);
endmodule

bind lvmon_ctrl lvmon_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n_i     (rst_n_i),
  .sys_rst_o   (sys_rst_o),
  .rst_pin_n_o (rst_pin_n_o),
  .irq_en      (irq_en),
  .flag        (flag),
  .status      (status),
  .above_s     (above_s),
  .active      (active),
  .cfg_rst_dis (cfg_rst_dis),
  .ack_wr      (ack_wr),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data)
);

// File: tb/sim_lvmon_ctrl.sv
`timescale 1ns/1ps
module sim_lvmon_ctrl;
  logic       clk = 1'b0;
  logic       por_n;
  logic       below, above;
  logic       pwr_dis, rst_dis, stop_en, stop;
  logic       wr_en;
  logic [0:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [1:0] trip;
  logic       irq, srst, pin_n;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;  // 250 MHz

  lvmon_ctrl u0 (
    .clk(clk), .por_n(por_n),
    .cmp_below_fall_i(below), .cmp_above_rise_i(above),
    .cfg_pwr_dis(pwr_dis), .cfg_rst_dis(rst_dis), .cfg_stop_en(stop_en),
    .stop_i(stop), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .trip_sel_o(trip),
    .irq_o(irq), .sys_rst_o(srst), .rst_pin_n_o(pin_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 1'(a);
    #1;
    v = int'(rd_data);
  endtask

  task automatic do_por();
    por_n = 1'b0;
    cyc(3);
    chk("R1 sys_rst during por", int'(srst), 0);
    por_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_reset();
    int v;
    do_por();
    chk("R1 sys_rst", int'(srst), 0);
    chk("R6 pin", int'(pin_n), 1);
    chk("R1 irq", int'(irq), 0);
    chk("R1 trip", int'(trip), 0);
    rd(0, v); chk("R1 ctrl", v, 0);
  endtask

  task automatic t_edges();
    int v;
    rst_dis = 1'b1;
    wr(0, 8'h01);                       // enable interrupt
    below = 1'b1; cyc(4);
    rd(0, v);
    chk("R2 status high", (v >> 3) & 1, 1);
    chk("R7 flag on rise", (v >> 2) & 1, 1);
    chk("R8 irq", int'(irq), 1);
    chk("R4 no reset when disabled", int'(srst), 0);
    wr(0, 8'h01);                       // ack bit 0: no clear
    rd(0, v); chk("R9 write0 keeps flag", (v >> 2) & 1, 1);
    chk("R9 ack reads 0", (v >> 1) & 1, 0);
    wr(0, 8'h03);                       // ack
    rd(0, v); chk("R9 ack clears", (v >> 2) & 1, 0);
    chk("R8 irq low", int'(irq), 0);
    below = 1'b0; cyc(4);
    rd(0, v);
    chk("R2 status low", (v >> 3) & 1, 0);
    chk("R7 flag on fall", (v >> 2) & 1, 1);
    wr(0, 8'h00);                       // disable interrupt, flag kept
    chk("R8 irq off with ie 0", int'(irq), 0);
    wr(0, 8'h02);
  endtask

  task automatic t_race();
    int v;
    rst_dis = 1'b1;
    @(negedge clk); below = 1'b1;       // status changes 2 edges later
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h02;   // ack on the toggle edge
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    rd(0, v); chk("R10 event survives ack", (v >> 2) & 1, 1);
    wr(0, 8'h02);
    below = 1'b0; cyc(4); wr(0, 8'h02);
  endtask

  task automatic t_lvreset();
    int v;
    wr(1, 8'h01);                       // raise trip select
    chk("R12 trip written", int'(trip), 1);
    rst_dis = 1'b0;
    wr(0, 8'h01);
    above = 1'b0; below = 1'b1; cyc(4);
    chk("R4 reset raised", int'(srst), 1);
    chk("R6 pin low", int'(pin_n), 0);
    rd(0, v); chk("R11 ie cleared", v & 1, 0);
    wr(0, 8'h01);
    rd(0, v); chk("R11 ie write ignored", v & 1, 0);
    below = 1'b0; cyc(6);
    chk("R5 held between levels", int'(srst), 1);
    above = 1'b1; cyc(4);
    chk("R5 released", int'(srst), 0);
    chk("R6 pin high", int'(pin_n), 1);
    chk("R12 trip survives", int'(trip), 1);
    do_por();
    chk("R12 trip after por", int'(trip), 0);
  endtask

  task automatic t_pwrdis();
    int v;
    rst_dis = 1'b0; pwr_dis = 1'b1;
    above = 1'b0; below = 1'b1; cyc(5);
    rd(0, v);
    chk("R3 status gated", (v >> 3) & 1, 0);
    chk("R3 no reset", int'(srst), 0);
    below = 1'b0; above = 1'b1; cyc(4);
    pwr_dis = 1'b0; cyc(2);
    wr(0, 8'h02);
  endtask

  task automatic t_stop();
    int v;
    rst_dis = 1'b1;
    below = 1'b1; cyc(4);
    stop = 1'b1; stop_en = 1'b0; cyc(1);
    rd(0, v); chk("R13 gated in stop", (v >> 3) & 1, 0);
    stop_en = 1'b1; cyc(1);
    rd(0, v); chk("R13 runs when allowed", (v >> 3) & 1, 1);
    stop = 1'b0; stop_en = 1'b0;
    below = 1'b0; cyc(4); wr(0, 8'h02);
  endtask

  initial begin
    por_n = 1'b0; below = 1'b0; above = 1'b1;
    pwr_dis = 1'b0; rst_dis = 1'b1; stop_en = 1'b0; stop = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    t_reset();
    t_edges();
    t_race();
    t_lvreset();
    t_pwrdis();
    t_stop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule